// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns buffer-access requests from a client into a legal stream of SDRAM commands for one chip select. The client asks for one of four operations: load the mode register, refresh, read one column, or write one column. Each request carries a row, a column and write data. The sequencer keeps track of whether a row is open and which row it is. It inserts the precharge-all and activate commands that a request needs, and it drives the active-low RAS, CAS and write-enable pins, a 14-bit address bus and a 32-bit data bus. At most one command goes out per clock, and NOOP goes out on every other cycle.

A separate down-counter enforces each minimum spacing between commands. The counts are parameters, and the defaults assume a 12 ns clock. A command goes out in the first cycle in which all of its counters have run out. Read data is captured a fixed number of cycles after READ and handed back with a one-cycle valid pulse.

The state machine has seven states. IDLE means no row is open and nothing is pending. OPEN means a row is open and nothing is pending. PRE waits to issue precharge-all. ACT waits to issue activate. COL waits to issue READ or WRT. REF waits to issue refresh. MRS waits to issue the mode register set.

The transitions are as follows:
- IDLE moves to MRS, REF or ACT on an accepted request, depending on its kind.
- OPEN moves to COL for a read or write to the open row. It moves to PRE for a different row, a refresh or a mode set.
- PRE moves to MRS, REF or ACT once the precharge has been issued, according to the pending kind.
- ACT moves to COL once the activate has been issued.
- COL moves to OPEN once the column command has been issued.
- REF and MRS move to IDLE once their command has been issued.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and right after reset the pins carry NOOP, `req_ready` is high, `rd_valid` is low and `sd_dq_oe` is low.
- R2: The pins {ras_n,cas_n,we_n} encode the commands as follows: activate 011, READ 101, WRT 100, precharge-all 010, refresh 001, mode set 000, NOOP 111.
- R3: Activate and refresh each keep these minimum spacings:
  - at least 2 cycles after a mode set;
  - at least 10 cycles after an activate or a refresh;
  - at least 3 cycles after a precharge-all.
  A mode set comes at least 3 cycles after a precharge-all.
- R4: Precharge-all comes at least 6 cycles after the activate and at least 2 cycles after the last WRT. It drives address bit 10 high and all other address bits low.
- R5: READ and WRT come at least 3 cycles after activate. Any column command comes at least 2 cycles after the previous READ or WRT. WRT comes at least 5 cycles after a READ.
- R6: On READ and WRT the address is the request column with bit 10 forced low. On activate it is the request row. On a mode set it is the value on `req_row`.
- R7: A read or write to the row that is already open issues only the column command. A request to another row first issues precharge-all, then activate with the new row.
- R8: A refresh or mode-set request that arrives while a row is open is preceded by precharge-all.
- R9: `sd_dq_in` is captured at the third rising edge after the edge that issues READ. `rd_valid` is high for exactly the following cycle, with the captured word on `rd_data`.
- R10: `sd_dq_oe` is high only in the cycle that carries WRT, and `sd_dq_out` then holds that request's write data.
- R11: `req_ready` is high only while no request is pending, and it drops right after an accept. Each command is issued in the first cycle that its spacings allow, but no earlier than two cycles after the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_kind | input | 2 | 0 mode set, 1 refresh, 2 read, 3 write |
| req_row | input | 14 | Row address, or mode value for a mode set |
| req_col | input | 14 | Column address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 14 | SDRAM address bus |
| sd_dq_out | output | 32 | Write data toward the SDRAM |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Read data from the SDRAM |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 32 | Captured read word |

## Verification
The bench aims at the cases where a single spacing decides the issue cycle:
- a READ followed by a WRT, where the 5-cycle read-to-write gap dominates;
- a precharge-all forced soon after an activate, where the 6-cycle row-active time dominates;
- the activate that follows, where the 10-cycle row cycle beats precharge recovery.

A design that used the wrong counter would issue a command early and break a minimum spacing. A design that waited for an unrelated counter would issue late, and the bench catches both because it checks the exact cycle. Row hits, row misses, a refresh with a row open and a column with bit 10 set are also covered. A design that left bit 10 set would auto-precharge, and a design that forgot precharge-all would refresh or change rows with a row still open. Read data comes from a bus whose value changes every cycle, so capturing one cycle early or late shows up as a wrong word.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MODE  = 3'b000,
        CMD_REFR  = 3'b001,
        CMD_PALL  = 3'b010,
        CMD_ACT   = 3'b011,
        CMD_WRT   = 3'b100,
        CMD_READ  = 3'b101,
        CMD_NOOP  = 3'b111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        K_MODE    = 2'd0,
        K_REFRESH = 2'd1,
        K_READ    = 2'd2,
        K_WRITE   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_PRE,
        S_ACT,
        S_COL,
        S_REF,
        S_MRS
    } seq_state_e;

    // spacing timer indices
    localparam int TI_MRD = 0;
    localparam int TI_RC  = 1;
    localparam int TI_RAS = 2;
    localparam int TI_RP  = 3;
    localparam int TI_RCD = 4;
    localparam int TI_CCD = 5;
    localparam int TI_CWL = 6;
    localparam int TI_RWD = 7;
    localparam int TI_WR  = 8;
    localparam int TI_N   = 9;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int W = (GAP > 2) ? $clog2(GAP) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= W'(GAP - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // a running gap counts down one per cycle until it expires (R3, R4, R5)
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && busy) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int LAT = 3,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [LAT-1:0] stage;

    generate
        if (LAT > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= '0;
                else        stage <= {stage[LAT-2:0], rd_issue};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= '0;
                else        stage <= rd_issue;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= stage[LAT-1];
            if (stage[LAT-1]) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int A_W     = 14,
    parameter int D_W     = 32,
    parameter int AP_BIT  = 10,
    parameter int T_MRD   = 2,
    parameter int T_RC    = 10,
    parameter int T_RAS   = 6,
    parameter int T_RP    = 3,
    parameter int T_RCD   = 3,
    parameter int T_CCD   = 2,
    parameter int T_CWL   = 2,
    parameter int T_RWD   = 5,
    parameter int T_WR    = 2,
    parameter int CAS_LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_kind,
    input  logic [A_W-1:0] req_row,
    input  logic [A_W-1:0] req_col,
    input  logic [D_W-1:0] req_wdata,
    output logic           req_ready,
    output logic           sd_ras_n,
    output logic           sd_cas_n,
    output logic           sd_we_n,
    output logic [A_W-1:0] sd_addr,
    output logic [D_W-1:0] sd_dq_out,
    output logic           sd_dq_oe,
    input  logic [D_W-1:0] sd_dq_in,
    output logic           rd_valid,
    output logic [D_W-1:0] rd_data
);
    localparam int GAPS [TI_N] = '{T_MRD, T_RC, T_RAS, T_RP, T_RCD,
                                   T_CCD, T_CWL, T_RWD, T_WR};

    seq_state_e     state, nxt;
    sd_cmd_e        issue, cmd_q;
    req_kind_e      pend_kind;
    logic [A_W-1:0] pend_row, pend_col, open_row;
    logic [D_W-1:0] pend_wdata;
    logic [TI_N-1:0] ld, busy;
    logic           accept, row_hit;
    logic           ok_act, ok_pall, ok_mode, ok_read, ok_wrt;

    // ---------------- spacing timers ----------------
    generate
        for (genvar i = 0; i < TI_N; i++) begin : g_tmr
            sdram_gap_timer #(.GAP(GAPS[i])) u_tmr (
                .clk  (clk),
                .rst_n(rst_n),
                .load (ld[i]),
                .busy (busy[i])
            );
        end
    endgenerate

    always_comb begin
        ld          = '0;
        ld[TI_MRD]  = (issue == CMD_MODE);
        ld[TI_RC]   = (issue == CMD_ACT) || (issue == CMD_REFR);
        ld[TI_RAS]  = (issue == CMD_ACT);
        ld[TI_RP]   = (issue == CMD_PALL);
        ld[TI_RCD]  = (issue == CMD_ACT);
        ld[TI_CCD]  = (issue == CMD_READ) || (issue == CMD_WRT);
        ld[TI_CWL]  = (issue == CMD_WRT);
        ld[TI_RWD]  = (issue == CMD_READ);
        ld[TI_WR]   = (issue == CMD_WRT);
    end

    assign ok_act  = !busy[TI_MRD] && !busy[TI_RC] && !busy[TI_RP];
    assign ok_pall = !busy[TI_RAS] && !busy[TI_WR];
    assign ok_mode = !busy[TI_RP];
    assign ok_read = !busy[TI_RCD] && !busy[TI_CCD] && !busy[TI_CWL];
    assign ok_wrt  = ok_read && !busy[TI_RWD];

    // ---------------- request side ----------------
    assign req_ready = (state == S_IDLE) || (state == S_OPEN);
    assign accept    = req_valid && req_ready;
    assign row_hit   = (req_row == open_row);

    // ---------------- next state and issue ----------------
    always_comb begin
        nxt   = state;
        issue = CMD_NOOP;
        unique case (state)
            S_IDLE: if (accept) begin
                unique case (req_kind_e'(req_kind))
                    K_MODE:    nxt = S_MRS;
                    K_REFRESH: nxt = S_REF;
                    default:   nxt = S_ACT;
                endcase
            end
            S_OPEN: if (accept) begin
                if (req_kind_e'(req_kind) == K_MODE || req_kind_e'(req_kind) == K_REFRESH
                    || !row_hit)
                    nxt = S_PRE;
                else
                    nxt = S_COL;
            end
            S_PRE: if (ok_pall) begin
                issue = CMD_PALL;
                unique case (pend_kind)
                    K_MODE:    nxt = S_MRS;
                    K_REFRESH: nxt = S_REF;
                    default:   nxt = S_ACT;
                endcase
            end
            S_ACT: if (ok_act) begin
                issue = CMD_ACT;
                nxt   = S_COL;
            end
            S_COL: begin
                if (pend_kind == K_WRITE && ok_wrt) begin
                    issue = CMD_WRT;
                    nxt   = S_OPEN;
                end else if (pend_kind == K_READ && ok_read) begin
                    issue = CMD_READ;
                    nxt   = S_OPEN;
                end
            end
            S_REF: if (ok_act) begin
                issue = CMD_REFR;
                nxt   = S_IDLE;
            end
            S_MRS: if (ok_mode) begin
                issue = CMD_MODE;
                nxt   = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // ---------------- request and row bookkeeping ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_kind  <= K_MODE;
            pend_row   <= '0;
            pend_col   <= '0;
            pend_wdata <= '0;
            open_row   <= '0;
        end else begin
            if (accept) begin
                pend_kind  <= req_kind_e'(req_kind);
                pend_row   <= req_row;
                pend_col   <= req_col;
                pend_wdata <= req_wdata;
            end
            if (issue == CMD_ACT) open_row <= pend_row;
        end
    end

    // ---------------- pin outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOOP;
            sd_addr   <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            cmd_q    <= issue;
            sd_dq_oe <= (issue == CMD_WRT);
            if (issue == CMD_WRT) sd_dq_out <= pend_wdata;
            unique case (issue)
                CMD_ACT, CMD_MODE: sd_addr <= pend_row;
                CMD_READ, CMD_WRT: begin
                    sd_addr         <= pend_col;
                    sd_addr[AP_BIT] <= 1'b0;
                end
                CMD_PALL: begin
                    sd_addr         <= '0;
                    sd_addr[AP_BIT] <= 1'b1;
                end
                default: sd_addr <= '0;
            endcase
        end
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    // ---------------- read capture ----------------
    sdram_rd_capture #(.LAT(CAS_LAT), .DW(D_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_issue(issue == CMD_READ),
        .dq_in   (sd_dq_in),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    // ---------------- assertions ----------------
    p_pall_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PALL) |-> sd_addr[AP_BIT]);

    p_col_no_autopre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ || cmd_q == CMD_WRT) |-> !sd_addr[AP_BIT]);

    p_accept_drops_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_oe_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd_q == CMD_WRT));

    generate
        if (T_RCD > 1) begin : g_rcd_chk
            p_no_col_after_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_q == CMD_ACT) |=> !(cmd_q == CMD_READ || cmd_q == CMD_WRT));
        end
    endgenerate

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;

    localparam logic [2:0] C_MODE = 3'b000, C_REFR = 3'b001, C_PALL = 3'b010,
                           C_ACT  = 3'b011, C_WRT  = 3'b100, C_READ = 3'b101,
                           C_NOOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [13:0] req_row = '0, req_col = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [13:0] sd_addr;
    logic [31:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [31:0] sd_dq_in = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    sdram_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .req_ready(req_ready), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [2:0]  code;
        logic [13:0] addr;
        logic [31:0] wd;
        int          acc;
        string       tag;
    } exp_cmd_t;

    typedef struct {
        int          at;
        logic [31:0] data;
    } exp_rd_t;

    exp_cmd_t exp_q[$];
    exp_rd_t  rd_q[$];

    int nchk = 0, nbad = 0;
    int cyc = 0;
    bit run = 0;
    bit model_open = 0;
    logic [13:0] model_row = '0;
    int last_mode = -1000, last_act = -1000, last_refr = -1000, last_pall = -1000,
        last_read = -1000, last_wrt = -1000;

    function automatic logic [31:0] bus_word(int c);
        return 32'hC0DE_0000 ^ 32'(c);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) sd_dq_in <= bus_word(cyc);

    function automatic void push(logic [2:0] code, logic [13:0] addr, logic [31:0] wd,
                                 int acc, string tag);
        exp_cmd_t e;
        e.code = code; e.addr = addr; e.wd = wd; e.acc = acc; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // driver: issue one request and push the commands it must produce
    task automatic do_req(int kind, logic [13:0] row, logic [13:0] col, logic [31:0] wd);
        int acc;
        bit first;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_row = row; req_col = col; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        first = 1;
        if (kind == 0 || kind == 1) begin
            if (model_open) begin
                push(C_PALL, 14'h0400, '0, acc, "R8");
                first = 0;
            end
            if (kind == 0) push(C_MODE, row, '0, first ? acc : -1000, "R2");
            else           push(C_REFR, '0, '0, first ? acc : -1000, "R2");
            model_open = 0;
        end else begin
            if (model_open && row != model_row) begin
                push(C_PALL, 14'h0400, '0, acc, "R7");
                first = 0;
                model_open = 0;
            end
            if (!model_open) begin
                push(C_ACT, row, '0, first ? acc : -1000, "R7");
                first = 0;
            end
            push(kind == 3 ? C_WRT : C_READ, col & ~14'h0400, wd,
                 first ? acc : -1000, "R7");
            model_open = 1;
            model_row  = row;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops expected commands and read words as the pins show them
    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [2:0] code;
            code = {sd_ras_n, sd_cas_n, sd_we_n};
            if (code != C_NOOP) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected command", 64'(code), 64'(C_NOOP));
                end else begin
                    exp_cmd_t it;
                    int lb;
                    string tt;
                    it = exp_q.pop_front();
                    chk(code == it.code, it.tag, "command code", 64'(code), 64'(it.code));
                    chk(sd_addr == it.addr, "R6", "address", 64'(sd_addr), 64'(it.addr));
                    lb = -1000;
                    tt = "R3";
                    case (code)
                        C_ACT, C_REFR: lb = imax(imax(last_mode + 2, last_pall + 3),
                                                 imax(last_act + 10, last_refr + 10));
                        C_MODE: lb = last_pall + 3;
                        C_PALL: begin lb = imax(last_act + 6, last_wrt + 2); tt = "R4"; end
                        C_READ: begin lb = imax(last_act + 3, imax(last_read + 2, last_wrt + 2)); tt = "R5"; end
                        C_WRT:  begin lb = imax(imax(last_act + 3, last_read + 5), last_wrt + 2); tt = "R5"; end
                        default: ;
                    endcase
                    chk(cyc >= lb, tt, "minimum spacing", 64'(cyc), 64'(lb));
                    chk(cyc == imax(lb, it.acc + 2), "R11", "earliest issue cycle",
                        64'(cyc), 64'(imax(lb, it.acc + 2)));
                    if (code == C_WRT)
                        chk(sd_dq_out == it.wd, "R10", "write data", 64'(sd_dq_out), 64'(it.wd));
                    if (code == C_READ) begin
                        exp_rd_t r;
                        r.at = cyc + 3;
                        r.data = bus_word(cyc + 2);
                        rd_q.push_back(r);
                    end
                end
                case (code)
                    C_MODE: last_mode = cyc;
                    C_ACT:  last_act  = cyc;
                    C_REFR: last_refr = cyc;
                    C_PALL: last_pall = cyc;
                    C_READ: last_read = cyc;
                    C_WRT:  last_wrt  = cyc;
                    default: ;
                endcase
            end
            if (code != C_NOOP || sd_dq_oe)
                chk(sd_dq_oe == (code == C_WRT), "R10", "data enable", 64'(sd_dq_oe),
                    64'(code == C_WRT));
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    chk(0, "R9", "read valid without READ", 64'(1), 64'(0));
                end else begin
                    exp_rd_t r;
                    r = rd_q.pop_front();
                    chk(cyc == r.at, "R9", "read valid cycle", 64'(cyc), 64'(r.at));
                    chk(rd_data == r.data, "R9", "read data", 64'(rd_data), 64'(r.data));
                end
            end
        end
    end

    task automatic stimulus();
        // reset state
        repeat (3) @(negedge clk);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == C_NOOP, "R1", "reset command",
            64'({sd_ras_n, sd_cas_n, sd_we_n}), 64'(C_NOOP));
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'(1));
        chk(rd_valid == 1'b0, "R1", "reset rd_valid", 64'(rd_valid), 64'(0));
        chk(sd_dq_oe == 1'b0, "R1", "reset dq_oe", 64'(sd_dq_oe), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == C_NOOP, "R1", "idle after reset",
            64'({sd_ras_n, sd_cas_n, sd_we_n}), 64'(C_NOOP));
        run = 1;

        do_req(0, 14'h0033, '0, '0);                 // mode set from idle (R2, R3)
        do_req(1, '0, '0, '0);                       // refresh after mode set (R3)
        do_req(2, 14'h0005, 14'h07FF, '0);           // bit 10 set in column (R6)
        do_req(2, 14'h0005, 14'h0004, '0);           // row hit read to read (R7, R5)
        do_req(3, 14'h0005, 14'h0008, 32'hA1B2C3D4); // read to write gap (R5, R10)
        do_req(3, 14'h0005, 14'h0009, 32'h0F0F1234); // write to write (R5)
        do_req(2, 14'h0005, 14'h000A, '0);           // write to read (R5)
        do_req(2, 14'h0009, 14'h0001, '0);           // row miss (R7, R4)
        do_req(1, '0, '0, '0);                       // refresh with row open (R8)
        do_req(2, 14'h0001, 14'h0002, '0);           // activate after refresh (R3)
        do_req(3, 14'h0003, 14'h0006, 32'h55AA55AA); // row miss soon after activate (R4, R3)
        do_req(0, 14'h0021, '0, '0);                 // mode set with row open (R8)
        do_req(3, 14'h0002, 14'h0003, 32'hDEADBEEF); // write from idle
        do_req(2, 14'h0002, 14'h0003, '0);           // read back same row

        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "pending commands", 64'(exp_q.size()), 64'(0));
        chk(rd_q.size() == 0, "R9", "pending read words", 64'(rd_q.size()), 64'(0));
    endtask

    initial begin
        fork
            stimulus();
            begin
                repeat (20000) @(posedge clk);
                nchk++; nbad++;
                $display("FAIL R11 watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule